// File: doc/BRIEF.md
# Clock Supervisor Control Register

This block is the software-facing control point of a clock generation module. It keeps one synthesizer control word, written through a small register port in three independently strobed lanes. The word holds the fault-response enables, an output clock disable, the modulation rate and depth, and an expected counter difference used for modulation calibration. The phase-locked loop, the clock-loss detector and the modulation hardware sit outside the block and reach it only as status inputs.

From the control word and the status inputs the block produces a reset request, an interrupt request, a gated copy of the system clock and a one-cycle pulse that starts modulation calibration. The requests are levels. They respond to a fault that is already flagged as soon as the matching enable is set. They are suppressed when the clock monitor is off, or when the module runs from an external clock.

Top module: `clksup_ctrl`

## Requirements
- R1: After synchronous reset every control field reads 0; `rd_data`, `rst_req`, `irq_req`, `cal_start` and `fm_en` are 0; `fm_ref_div` is 80; `clk_out` follows `clk`.
- R2: A write with `wr_en` high updates only the lanes whose `wr_mask` bit is set. Lane 0 (`wr_mask[0]`) carries the flags in bits 3:0: bit 0 output disable, bit 1 lock-loss interrupt enable, bit 2 clock-loss interrupt enable, bit 3 clock-loss reset enable. Lane 1 carries the rate in bit 4 and the depth in bits 6:5. Lane 2 carries the expected difference in bits 16:7. `rd_data` returns the stored word in the same layout in the cycle after the write.
- R3: A lane-1 write with depth code 2'b11 (reserved) leaves the stored depth unchanged; the rate bit of that write is still stored. Codes 00, 01 and 10 are stored.
- R4: `rst_req` is 1 in the cycle after the clock edge where `clk_lost`, `mon_en` and the reset enable are all 1 in a non-external mode. It stays high while these hold and falls one cycle after any of them drops.
- R5: `irq_req` is 1 one cycle after `clk_lost`, `mon_en` and the clock-loss interrupt enable are all 1 in a non-external mode, including when the enable is set while the flag is already up.
- R6: `irq_req` is 1 one cycle after the lock-loss interrupt enable is 1 while `pll_locked` is 0 or `lock_lost` is 1, in normal (`op_mode` 2'b00) or one-to-one (2'b01) mode.
- R7: With `mon_en` 0, the clock-loss reset enable and the clock-loss interrupt enable cause no request.
- R8: In external clock mode (`op_mode` 2'b10, and the reserved code 2'b11, handled the same way), neither request is raised whatever the enables and status inputs are.
- R9: With the output disable bit at 1, `clk_out` is low from the next rising edge of `clk` after the falling edge that follows the write. With the bit at 0, `clk_out` equals `clk`.
- R10: `cal_start` is high for exactly the cycle after a write that touches lane 1 or lane 2, provided an expected value has been loaded by that write or by an earlier one.
- R11: A lane-1 write before any lane-2 write since reset produces no `cal_start` pulse.
- R12: `fm_ref_div` is 80 when the stored rate bit is 0 and 40 when it is 1.
- R13: `fm_en` is 1 when the stored depth is nonzero or an expected value has been loaded since reset, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_mask | input | 3 | Lane select for the write: 0 flags, 1 rate/depth, 2 expected |
| wr_data | input | 17 | Write data in the register layout |
| rd_data | output | 17 | Current register contents |
| clk_lost | input | 1 | Clock-loss status flag from the detector |
| lock_lost | input | 1 | Lock-loss status flag from the PLL |
| pll_locked | input | 1 | PLL currently locked |
| op_mode | input | 2 | 00 normal, 01 one-to-one, 10 external, 11 treated as external |
| mon_en | input | 1 | Clock monitor enabled |
| rst_req | output | 1 | Reset request level |
| irq_req | output | 1 | Interrupt request level |
| clk_out | output | 1 | Gated system clock |
| cal_start | output | 1 | One-cycle modulation calibration start |
| fm_en | output | 1 | Frequency modulation enabled |
| fm_ref_div | output | 7 | Reference divider chosen by the rate bit |

## Verification
The fault logic is driven from a table whose rows each flip one condition: the mode (normal, one-to-one, external, the reserved code), monitor enable, clock-loss and lock-loss status, and each enable on its own. A wrong gating term therefore changes exactly one expected request. Directed sequences cover the rest. One sets an enable with the fault already present and then clears the fault, which tells a level request from an edge-only one. Others write the reserved depth code alongside a rate change, and issue lane-1 writes before and after the first expected-value load. Those show whether calibration gating and depth filtering act per field or per write.

// File: rtl/clksup_pkg.sv
package clksup_pkg;

    // operating mode of the clock module
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_ONE2ONE = 2'b01,
        MODE_EXTERNAL = 2'b10,
        MODE_RESERVED = 2'b11
    } op_mode_e;

    // modulation depth codes
    typedef enum logic [1:0] {
        DEPTH_NONE = 2'b00,
        DEPTH_1PCT = 2'b01,
        DEPTH_2PCT = 2'b10,
        DEPTH_RSVD = 2'b11
    } depth_e;

    // fault response and output flags, MSB first
    typedef struct packed {
        logic rst_en;
        logic cl_irq_en;
        logic ll_irq_en;
        logic out_dis;
    } flags_t;

    localparam int FLAG_W    = $bits(flags_t);
    localparam int POS_RATE  = FLAG_W;
    localparam int POS_DEPTH = POS_RATE + 1;
    localparam int POS_EXP   = POS_DEPTH + 2;

    localparam int LANE_CTL = 0;
    localparam int LANE_MOD = 1;
    localparam int LANE_EXP = 2;
    localparam int LANES    = 3;

    localparam int DIV_W    = 7;
    localparam logic [DIV_W-1:0] DIV_SLOW = 7'd80;
    localparam logic [DIV_W-1:0] DIV_FAST = 7'd40;

    function automatic logic is_ext(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic depth_legal(input logic [1:0] d);
        return d != DEPTH_RSVD;
    endfunction

    function automatic logic [DIV_W-1:0] ref_div(input logic r);
        return r ? DIV_FAST : DIV_SLOW;
    endfunction

endpackage

// File: rtl/clksup_regs.sv
module clksup_regs
    import clksup_pkg::*;
#(
    parameter int EXP_W = 10,
    localparam int DW = POS_EXP + EXP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_mask,
    input  logic [DW-1:0]    wr_data,
    output flags_t           flags,
    output logic             rate,
    output depth_e           depth,
    output logic             exp_loaded,
    output logic             cal_start,
    output logic [DW-1:0]    rd_data
);

    logic [EXP_W-1:0] exp_val;
    logic             hit_mod;
    logic             hit_exp;
    logic [1:0]       depth_in;

    assign hit_mod  = wr_en && wr_mask[LANE_MOD];
    assign hit_exp  = wr_en && wr_mask[LANE_EXP];
    assign depth_in = wr_data[POS_DEPTH +: 2];

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            rate       <= 1'b0;
            depth      <= DEPTH_NONE;
            exp_val    <= '0;
            exp_loaded <= 1'b0;
            cal_start  <= 1'b0;
        end else begin
            if (wr_en && wr_mask[LANE_CTL])
                flags <= flags_t'(wr_data[FLAG_W-1:0]);
            if (hit_mod) begin
                rate <= wr_data[POS_RATE];
                if (depth_legal(depth_in))
                    depth <= depth_e'(depth_in);
            end
            if (hit_exp) begin
                exp_val    <= wr_data[POS_EXP +: EXP_W];
                exp_loaded <= 1'b1;
            end
            cal_start <= (hit_mod || hit_exp) && (exp_loaded || hit_exp);
        end
    end

    assign rd_data = {exp_val, depth, rate, flags};

endmodule

// File: rtl/clksup_fault.sv
module clksup_fault
    import clksup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flags_t     flags,
    input  logic [1:0] op_mode,
    input  logic       mon_en,
    input  logic       clk_lost,
    input  logic       lock_lost,
    input  logic       pll_locked,
    output logic       rst_req,
    output logic       irq_req
);

    logic pll_run;
    logic cl_seen;
    logic lk_bad;
    logic rst_d;
    logic irq_d;

    always_comb begin
        pll_run = !is_ext(op_mode);
        cl_seen = pll_run && mon_en && clk_lost;
        lk_bad  = pll_run && (!pll_locked || lock_lost);
        rst_d   = cl_seen && flags.rst_en;
        irq_d   = (cl_seen && flags.cl_irq_en) || (lk_bad && flags.ll_irq_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            irq_req <= 1'b0;
        end else begin
            rst_req <= rst_d;
            irq_req <= irq_d;
        end
    end

endmodule

// File: rtl/clksup_clkgate.sv
module clksup_clkgate (
    input  logic clk,
    input  logic rst,
    input  logic disable_out,
    output logic clk_out
);

    // enable changes only while clk is low, so clk_out never glitches
    logic en_q;

    always_ff @(negedge clk) begin
        if (rst) en_q <= 1'b1;
        else     en_q <= !disable_out;
    end

    assign clk_out = clk & en_q;

endmodule

// File: rtl/clksup_ctrl.sv
module clksup_ctrl
    import clksup_pkg::*;
#(
    parameter int EXP_W = 10,
    localparam int DW = POS_EXP + EXP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_mask,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic             clk_lost,
    input  logic             lock_lost,
    input  logic             pll_locked,
    input  logic [1:0]       op_mode,
    input  logic             mon_en,
    output logic             rst_req,
    output logic             irq_req,
    output logic             clk_out,
    output logic             cal_start,
    output logic             fm_en,
    output logic [DIV_W-1:0] fm_ref_div
);

    flags_t flags;
    logic   rate;
    depth_e depth;
    logic   exp_loaded;

    clksup_regs #(.EXP_W(EXP_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_mask    (wr_mask),
        .wr_data    (wr_data),
        .flags      (flags),
        .rate       (rate),
        .depth      (depth),
        .exp_loaded (exp_loaded),
        .cal_start  (cal_start),
        .rd_data    (rd_data)
    );

    clksup_fault u_fault (
        .clk        (clk),
        .rst        (rst),
        .flags      (flags),
        .op_mode    (op_mode),
        .mon_en     (mon_en),
        .clk_lost   (clk_lost),
        .lock_lost  (lock_lost),
        .pll_locked (pll_locked),
        .rst_req    (rst_req),
        .irq_req    (irq_req)
    );

    clksup_clkgate u_gate (
        .clk         (clk),
        .rst         (rst),
        .disable_out (flags.out_dis),
        .clk_out     (clk_out)
    );

    assign fm_en      = (depth != DEPTH_NONE) || exp_loaded;
    assign fm_ref_div = ref_div(rate);

endmodule

// File: rtl/clksup_chk.sv
module clksup_chk
    import clksup_pkg::*;
#(
    parameter int DW = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [LANES-1:0] wr_mask,
    input logic [DW-1:0]    rd_data,
    input logic             clk_lost,
    input logic             lock_lost,
    input logic             pll_locked,
    input logic [1:0]       op_mode,
    input logic             mon_en,
    input logic             rst_req,
    input logic             irq_req,
    input logic             clk_out,
    input logic             cal_start,
    input logic [DIV_W-1:0] fm_ref_div
);

    // R4 R7: a reset request needs a monitored clock loss the cycle before
    assert_rst_cause_R4: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ($past(clk_lost) && $past(mon_en)));

    // R8: no request of either kind follows an external-mode cycle
    assert_ext_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (rst_req || irq_req) |-> !$past(op_mode[1]));

    // R5 R6: an interrupt needs a monitored clock loss or a lock problem
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (($past(mon_en) && $past(clk_lost)) ||
                     !$past(pll_locked) || $past(lock_lost)));

    // R10: calibration only follows a write to the rate or expected lane
    assert_cal_after_write_R10: assert property (@(posedge clk) disable iff (rst)
        cal_start |-> ($past(wr_en) && ($past(wr_mask[LANE_MOD]) || $past(wr_mask[LANE_EXP]))));

    // R9: the gated clock is never high while clk is low
    assert_gate_low_R9: assert property (@(posedge clk) disable iff (rst)
        !clk_out);

    // R3: the reserved depth code is never stored
    assert_depth_legal_R3: assert property (@(posedge clk) disable iff (rst)
        rd_data[POS_DEPTH +: 2] != DEPTH_RSVD);

    // R12: divider is one of the two legal choices and tracks the stored rate
    assert_div_rate_R12: assert property (@(posedge clk) disable iff (rst)
        fm_ref_div == (rd_data[POS_RATE] ? DIV_FAST : DIV_SLOW));

endmodule

bind clksup_ctrl clksup_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_mask    (wr_mask),
    .rd_data    (rd_data),
    .clk_lost   (clk_lost),
    .lock_lost  (lock_lost),
    .pll_locked (pll_locked),
    .op_mode    (op_mode),
    .mon_en     (mon_en),
    .rst_req    (rst_req),
    .irq_req    (irq_req),
    .clk_out    (clk_out),
    .cal_start  (cal_start),
    .fm_ref_div (fm_ref_div)
);

// File: tb/tb_clksup_ctrl.sv
module tb_clksup_ctrl;

    localparam int EW = 10;
    localparam int DW = 7 + EW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_mask = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          clk_lost = 1'b0;
    logic          lock_lost = 1'b0;
    logic          pll_locked = 1'b1;
    logic [1:0]    op_mode = 2'b00;
    logic          mon_en = 1'b0;
    logic          rst_req, irq_req, clk_out, cal_start, fm_en;
    logic [6:0]    fm_ref_div;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clksup_ctrl #(.EXP_W(EW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_data(wr_data), .rd_data(rd_data), .clk_lost(clk_lost),
        .lock_lost(lock_lost), .pll_locked(pll_locked), .op_mode(op_mode),
        .mon_en(mon_en), .rst_req(rst_req), .irq_req(irq_req),
        .clk_out(clk_out), .cal_start(cal_start), .fm_en(fm_en),
        .fm_ref_div(fm_ref_div)
    );

    // vector: [11:10] mode, [9] mon_en, [8] clk_lost, [7] lock_lost,
    // [6] pll_locked, [5:2] flags {rst_en, cl_irq, ll_irq, out_dis},
    // [1] expected rst_req, [0] expected irq_req
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        12'b00_1_1_0_1_1000_10,   // R4 clock-loss reset
        12'b00_1_1_0_1_0100_01,   // R5 clock-loss interrupt
        12'b00_0_1_0_1_1100_00,   // R7 monitor off
        12'b10_1_1_0_0_1110_00,   // R8 external mode
        12'b11_1_1_0_0_1110_00,   // R8 reserved mode as external
        12'b01_1_0_0_0_0010_01,   // R6 unlocked in one-to-one mode
        12'b00_1_0_1_1_0010_01,   // R6 lock-loss flag in normal mode
        12'b00_1_0_0_1_0010_00,   // R6 locked, no flag
        12'b00_1_0_0_1_1100_00,   // R4 no fault flagged
        12'b01_1_1_0_1_1000_10    // R4 one-to-one mode
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive a write at the falling edge; returns 1 ns after the capturing edge
    task automatic do_write(input logic [2:0] m, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mask = m; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tick;
        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 cal_start", cal_start, 0);
        chk("R1 fm_en", fm_en, 0);
        chk("R1 fm_ref_div", fm_ref_div, 80);
        @(posedge clk); #2;
        chk("R1 clk_out high phase", clk_out, 1);

        // table walk of the fault logic
        for (int i = 0; i < NV; i++) begin
            op_mode    = VEC[i][11:10];
            mon_en     = VEC[i][9];
            clk_lost   = VEC[i][8];
            lock_lost  = VEC[i][7];
            pll_locked = VEC[i][6];
            do_write(3'b001, {{(DW-4){1'b0}}, VEC[i][5:2]});
            tick;
            chk($sformatf("R4/R7/R8 rst_req vec %0d", i), rst_req, VEC[i][1]);
            chk($sformatf("R5/R6/R8 irq_req vec %0d", i), irq_req, VEC[i][0]);
        end

        // R4 level behaviour: enable set with fault already flagged, then fault clears
        op_mode = 2'b00; mon_en = 1'b1; pll_locked = 1'b1; lock_lost = 1'b0;
        clk_lost = 1'b1;
        do_write(3'b001, 17'h8);
        tick;
        chk("R4 immediate on enable", rst_req, 1);
        repeat (3) tick;
        chk("R4 held as level", rst_req, 1);
        @(negedge clk) clk_lost = 1'b0;
        tick;
        chk("R4 drops with flag", rst_req, 0);
        // R5 enable set while flag already up
        @(negedge clk) clk_lost = 1'b1;
        do_write(3'b001, 17'h4);
        tick;
        chk("R5 irq on late enable", irq_req, 1);
        chk("R5 rst_req off", rst_req, 0);
        // R7 monitor off removes request
        @(negedge clk) mon_en = 1'b0;
        tick;
        chk("R7 monitor off", irq_req, 0);
        clk_lost = 1'b0; mon_en = 1'b1;

        // R2 lane masking and readback
        do_write(3'b001, 17'h0);
        do_write(3'b100, {10'h2A5, 7'h7F});
        chk("R2 only expected lane", rd_data, {10'h2A5, 7'h00});
        chk("R10 cal on expected write", cal_start, 1);
        tick;
        chk("R10 cal single cycle", cal_start, 0);
        chk("R13 fm_en after expected load", fm_en, 1);

        // R9 output clock gating
        do_write(3'b001, 17'h1);
        chk("R2 flags lane", rd_data, {10'h2A5, 7'h01});
        @(posedge clk); #2;
        chk("R9 clk_out held low", clk_out, 0);
        do_write(3'b001, 17'h0);
        @(posedge clk); #2;
        chk("R9 clk_out follows clk", clk_out, 1);

        // R3 reserved depth kept, rate still stored
        do_write(3'b010, 17'h20);           // depth 01, rate 0
        chk("R3 depth 01 stored", rd_data[6:5], 2'b01);
        chk("R10 cal on rate lane", cal_start, 1);
        do_write(3'b010, 17'h70);           // depth 11, rate 1
        chk("R3 reserved depth ignored", rd_data[6:5], 2'b01);
        chk("R3 rate stored", rd_data[4], 1);
        chk("R12 rate 1 divides by 40", fm_ref_div, 40);
        do_write(3'b010, 17'h40);           // depth 10, rate 0
        chk("R3 depth 10 stored", rd_data[6:5], 2'b10);
        chk("R12 rate 0 divides by 80", fm_ref_div, 80);

        // R11 and R13 after a fresh reset: no expected value loaded yet
        @(negedge clk) rst = 1'b1;
        tick;
        @(negedge clk) rst = 1'b0;
        do_write(3'b010, 17'h10);           // rate 1, depth 00
        chk("R11 no cal before expected load", cal_start, 0);
        chk("R13 fm_en off with depth 0", fm_en, 0);
        chk("R12 rate 1 after reset", fm_ref_div, 40);
        do_write(3'b010, 17'h30);           // depth 01
        chk("R11 still no cal", cal_start, 0);
        chk("R13 fm_en with depth", fm_en, 1);
        do_write(3'b110, {10'h001, 7'h00}); // expected + depth 00 together
        chk("R10 cal on combined write", cal_start, 1);
        chk("R13 fm_en by expected load", fm_en, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule